// File: doc/BRIEF.md
# PLL Bring-Up Configuration Sequencer

This block brings a PLL clock controller out of reset without software help. A one-cycle start pulse carries a reference clock rate in kHz. The block first decodes that rate into the controller's sparse reference index. If the rate is not one the controller supports, it stops at once with an error and issues no bus traffic.

For a supported rate, the block acts as the only master on a simple 32-bit register bus and works through the configuration steps. Each step is a read-modify-write of one register, so the other bits of that register keep their values. The steps are:
- program the reference index, plus a predivider for the 96 MHz input;
- enable lock detection;
- pulse the analog soft reset low for a timed hold;
- poll the lock status at a fixed interval until it sets or a poll budget runs out.

On success the block reads the feedback factor that the PLL chose for itself and reports the resulting output rate. Done and error stay set until the next accepted start.

Top module: `pll_bringup_seq`

## Requirements
- R1: Reference rates map to a 4-bit index: 25000 kHz→3, 31250→4, 40000→6, 48000→7, 96000→7, 50000→8. Any other rate ends the attempt in the same cycle with error=1 and err_code=2'b01. In that case busy stays 0, done stays 0 and no bus transaction is made.
- R2: The sequence starts by reading address 0x784 and writing it back with the index in bits [3:0]. Every other bit is preserved, except as R3 states.
- R3: Only for 96000 kHz, the same write to 0x784 also puts 2 into bits [8:4]. The block then read-modify-writes 0x028 with bits [9:8] cleared. Other rates never touch 0x028.
- R4: After the reference setup, 0x78C is read and written back with bit 15 set and all other bits preserved.
- R5: Address 0x780 is read and written back with bit 6 cleared. After at least HOLD_US×CYC_PER_US cycles, and with no bus transaction in between, it is written again with bit 6 set. All other bits keep the value that was read.
- R6: After the reset release, 0x064 is read once per POLL_US×CYC_PER_US cycles (at least). When bit 8 reads 1, the block reads 0x794, raises done and drops busy.
- R7: If TIMEOUT_US/POLL_US consecutive reads of 0x064 all show bit 8 at 0, the sequence ends with error=1 and err_code=2'b10. Register 0x794 is not read.
- R8: On success, pll_rate_khz equals ref_khz × 2 × bits [9:0] of the value read from 0x794. Higher bits of that value are ignored.
- R9: bus_req stays high until bus_ready is seen. While it waits, bus_we, bus_addr and bus_wdata are held stable. Read data is taken in the cycle bus_ready is high.
- R10: A start pulse that arrives while busy is 1 has no effect on the sequence in progress.
- R11: Busy is 1 from the cycle after an accepted start until the end of the sequence. Done and error are sticky until the next accepted start, which clears both. Done and error are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin bring-up |
| ref_khz | input | 17 | Reference rate in kHz, sampled with start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sticky success flag |
| error | output | 1 | Sticky failure flag |
| err_code | output | 2 | 00 none, 01 unsupported rate, 10 lock timeout |
| pll_rate_khz | output | 32 | Reported PLL output rate in kHz |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 12 | Byte address of the 32-bit register |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Slave completes the transaction this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |

## Verification
The 96 MHz input is the main corner case. A design that handled it like 48 MHz would leave the predivider field untouched and never visit 0x028. A design that widened the field masks would instead corrupt neighbouring bits that the bench preloads with ones.

The bench watches the soft-reset hold for two faults: a short hold, and any stray transaction between the low and high writes. It also checks that the release restores the bits originally read.

A lock that never arrives must stop after exactly the poll budget, not one read early or late, and must report the timeout code rather than the unsupported code. A rate outside the table must produce no bus traffic at all. A second start during a run must not restart the sequence or change the index.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int RATE_W = 17;

    localparam logic [ADDR_W-1:0] A_SRCSEL = 12'h028;
    localparam logic [ADDR_W-1:0] A_LOCK   = 12'h064;
    localparam logic [ADDR_W-1:0] A_RST    = 12'h780;
    localparam logic [ADDR_W-1:0] A_REFCFG = 12'h784;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h78C;
    localparam logic [ADDR_W-1:0] A_FACTOR = 12'h794;

    localparam int IDX_LSB    = 0;
    localparam int IDX_W      = 4;
    localparam int PDIV_LSB   = 4;
    localparam int PDIV_W     = 5;
    localparam int SDIV_LSB   = 8;
    localparam int SDIV_W     = 2;
    localparam int LDET_BIT   = 15;
    localparam int RSTN_BIT   = 6;
    localparam int LOCK_BIT   = 8;
    localparam int FACTOR_W   = 10;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'b00,
        ERR_UNSUP = 2'b01,
        ERR_TMO   = 2'b10
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_REF, S_WR_REF, S_RD_SRC, S_WR_SRC,
        S_RD_CTL, S_WR_CTL, S_RD_RST, S_WR_RSTLO, S_HOLD,
        S_WR_RSTHI, S_POLL_WAIT, S_RD_LOCK, S_RD_FAC
    } seq_st_e;

    typedef struct packed {
        logic             ok;
        logic [IDX_W-1:0] idx;
        logic             predivide;
    } ref_dec_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_cmd_t;

    function automatic ref_dec_t decode_ref(input logic [RATE_W-1:0] khz);
        ref_dec_t d;
        d = '0;
        d.ok = 1'b1;
        case (khz)
            17'd25000: d.idx = 4'd3;
            17'd31250: d.idx = 4'd4;
            17'd40000: d.idx = 4'd6;
            17'd48000: d.idx = 4'd7;
            17'd96000: begin d.idx = 4'd7; d.predivide = 1'b1; end
            17'd50000: d.idx = 4'd8;
            default:   d.ok  = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pbs_rate_decode.sv
module pbs_rate_decode
    import pbs_pkg::*;
(
    input  logic [RATE_W-1:0] khz,
    output ref_dec_t          dec
);
    always_comb dec = decode_ref(khz);

    // R1
    always_comb begin
        idx_legal_chk: assert (!dec.ok || (dec.idx inside {4'd3, 4'd4, 4'd6, 4'd7, 4'd8}));
    end
endmodule

// File: rtl/pbs_timer.sv
module pbs_timer #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R5
    tmr_load_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));
endmodule

// File: rtl/pbs_bus_master.sv
module pbs_bus_master
    import pbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  bus_cmd_t          cmd,
    output logic              ack,
    output logic [DATA_W-1:0] ack_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            ack       <= 1'b0;
            ack_rdata <= '0;
        end else begin
            ack <= 1'b0;
            if (bus_req) begin
                if (bus_ready) begin
                    bus_req   <= 1'b0;
                    ack       <= 1'b1;
                    ack_rdata <= bus_rdata;
                end
            end else if (go) begin
                bus_req   <= 1'b1;
                bus_we    <= cmd.we;
                bus_addr  <= cmd.addr;
                bus_wdata <= cmd.wdata;
            end
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R9
    ack_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> !bus_req);
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
    import pbs_pkg::*;
#(
    parameter int CYC_PER_US = 125,
    parameter int HOLD_US    = 1000,
    parameter int POLL_US    = 100,
    parameter int TIMEOUT_US = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [16:0]       ref_khz,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [1:0]        err_code,
    output logic [31:0]       pll_rate_khz,
    output logic              bus_req,
    output logic              bus_we,
    output logic [11:0]       bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ready,
    input  logic [31:0]       bus_rdata
);
    localparam int HOLD_CYC  = CYC_PER_US * HOLD_US;
    localparam int POLL_CYC  = CYC_PER_US * POLL_US;
    localparam int TMR_MAX   = (HOLD_CYC > POLL_CYC) ? HOLD_CYC : POLL_CYC;
    localparam int TMR_W     = $clog2(TMR_MAX + 1);
    localparam int RAW_POLLS = TIMEOUT_US / POLL_US;
    localparam int MAX_POLLS = (RAW_POLLS < 1) ? 1 : RAW_POLLS;
    localparam int POLL_W    = $clog2(MAX_POLLS + 1);

    seq_st_e           st;
    logic              pend;
    logic [DATA_W-1:0] shadow;
    logic [RATE_W-1:0] ref_q;
    ref_dec_t          dec_now, dec_q;
    err_e              err_q;
    logic              done_q;
    logic [31:0]       rate_q;
    logic [POLL_W-1:0] poll_cnt;

    bus_cmd_t          cmd;
    logic              bus_state;
    logic              cmd_go;
    logic              ack;
    logic [DATA_W-1:0] ack_rdata;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              locked;
    logic              last_poll;

    pbs_rate_decode u_dec (
        .khz (ref_khz),
        .dec (dec_now)
    );

    pbs_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    pbs_bus_master u_bus (
        .clk       (clk),
        .rst       (rst),
        .go        (cmd_go),
        .cmd       (cmd),
        .ack       (ack),
        .ack_rdata (ack_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata)
    );

    // Per-state command: address, direction and modified write value
    always_comb begin
        cmd       = '0;
        cmd.wdata = shadow;
        bus_state = 1'b1;
        unique case (st)
            S_RD_REF:   cmd.addr = A_REFCFG;
            S_WR_REF: begin
                cmd.we   = 1'b1;
                cmd.addr = A_REFCFG;
                cmd.wdata[IDX_LSB +: IDX_W] = dec_q.idx;
                if (dec_q.predivide)
                    cmd.wdata[PDIV_LSB +: PDIV_W] = 5'd2;
            end
            S_RD_SRC:   cmd.addr = A_SRCSEL;
            S_WR_SRC: begin
                cmd.we   = 1'b1;
                cmd.addr = A_SRCSEL;
                cmd.wdata[SDIV_LSB +: SDIV_W] = '0;
            end
            S_RD_CTL:   cmd.addr = A_CTRL;
            S_WR_CTL: begin
                cmd.we   = 1'b1;
                cmd.addr = A_CTRL;
                cmd.wdata[LDET_BIT] = 1'b1;
            end
            S_RD_RST:   cmd.addr = A_RST;
            S_WR_RSTLO: begin
                cmd.we   = 1'b1;
                cmd.addr = A_RST;
                cmd.wdata[RSTN_BIT] = 1'b0;
            end
            S_WR_RSTHI: begin
                cmd.we   = 1'b1;
                cmd.addr = A_RST;
                cmd.wdata[RSTN_BIT] = 1'b1;
            end
            S_RD_LOCK:  cmd.addr = A_LOCK;
            S_RD_FAC:   cmd.addr = A_FACTOR;
            default:    bus_state = 1'b0;
        endcase
    end

    assign cmd_go    = bus_state && !pend;
    assign locked    = ack_rdata[LOCK_BIT];
    assign last_poll = (poll_cnt == POLL_W'(MAX_POLLS - 1));
    assign tmr_load  = ack && ((st == S_WR_RSTLO) || (st == S_WR_RSTHI) || (st == S_RD_LOCK));
    assign tmr_val   = (st == S_WR_RSTLO) ? TMR_W'(HOLD_CYC) : TMR_W'(POLL_CYC);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            pend     <= 1'b0;
            shadow   <= '0;
            ref_q    <= '0;
            dec_q    <= '0;
            err_q    <= ERR_NONE;
            done_q   <= 1'b0;
            rate_q   <= '0;
            poll_cnt <= '0;
        end else begin
            if (cmd_go)
                pend <= 1'b1;
            if (ack) begin
                pend <= 1'b0;
                if (!cmd.we)
                    shadow <= ack_rdata;
            end
            unique case (st)
                S_IDLE: if (start) begin
                    done_q   <= 1'b0;
                    ref_q    <= ref_khz;
                    dec_q    <= dec_now;
                    poll_cnt <= '0;
                    if (dec_now.ok) begin
                        err_q <= ERR_NONE;
                        st    <= S_RD_REF;
                    end else begin
                        err_q <= ERR_UNSUP;
                    end
                end
                S_RD_REF:   if (ack) st <= S_WR_REF;
                S_WR_REF:   if (ack) st <= dec_q.predivide ? S_RD_SRC : S_RD_CTL;
                S_RD_SRC:   if (ack) st <= S_WR_SRC;
                S_WR_SRC:   if (ack) st <= S_RD_CTL;
                S_RD_CTL:   if (ack) st <= S_WR_CTL;
                S_WR_CTL:   if (ack) st <= S_RD_RST;
                S_RD_RST:   if (ack) st <= S_WR_RSTLO;
                S_WR_RSTLO: if (ack) st <= S_HOLD;
                S_HOLD:     if (tmr_zero) st <= S_WR_RSTHI;
                S_WR_RSTHI: if (ack) st <= S_POLL_WAIT;
                S_POLL_WAIT: if (tmr_zero) st <= S_RD_LOCK;
                S_RD_LOCK: if (ack) begin
                    if (locked) begin
                        st <= S_RD_FAC;
                    end else if (last_poll) begin
                        err_q <= ERR_TMO;
                        st    <= S_IDLE;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                        st       <= S_POLL_WAIT;
                    end
                end
                S_RD_FAC: if (ack) begin
                    rate_q <= 32'(ref_q) * 32'(ack_rdata[FACTOR_W-1:0]) * 32'd2;
                    done_q <= 1'b1;
                    st     <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy         = (st != S_IDLE);
    assign done         = done_q;
    assign error        = (err_q != ERR_NONE);
    assign err_code     = err_q;
    assign pll_rate_khz = rate_q;

    // R5
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_HOLD) |-> !bus_req);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(ref_q));

    // R7
    poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
        poll_cnt < POLL_W'(MAX_POLLS));

    // R1
    unsup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q == ERR_UNSUP) |-> (!busy && !bus_req));
endmodule

// File: tb/pll_bringup_seq_tb_top.sv
module pll_bringup_seq_tb_top;

    localparam int CPU  = 1;
    localparam int HUS  = 20;
    localparam int PUS  = 6;
    localparam int TUS  = 60;
    localparam int HOLD = CPU * HUS;
    localparam int POLL = CPU * PUS;
    localparam int NPOLL = TUS / PUS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [16:0] ref_khz = '0;
    logic busy, done, error;
    logic [1:0] err_code;
    logic [31:0] pll_rate_khz;
    logic bus_req, bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic ready_r;
    logic [31:0] rdata_r;

    always #4 clk = ~clk;

    pll_bringup_seq #(.CYC_PER_US(CPU), .HOLD_US(HUS), .POLL_US(PUS), .TIMEOUT_US(TUS)) dut_i (
        .clk(clk), .rst(rst), .start(start), .ref_khz(ref_khz),
        .busy(busy), .done(done), .error(error), .err_code(err_code),
        .pll_rate_khz(pll_rate_khz),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(ready_r), .bus_rdata(rdata_r)
    );

    // Behavioural register slave with a transaction log
    logic [31:0] pre_ref = 32'hA5A5_A5A5, pre_src = 32'hFFFF_FFFF, pre_ctl = 32'h0000_0001;
    logic [31:0] pre_rst = 32'h1234_5678, pre_fac = 32'hFFFF_FC3C;
    int lock_after = 0;
    logic log_clr = 1'b0;

    logic [31:0] r_src, r_rst, r_ref, r_ctl, r_fac;
    logic [31:0] w_ref, w_src, w_ctl, w_rstlo, w_rsthi;
    int txn, wcnt, lock_reads, fac_reads, n_wr_ref, n_wr_src, n_wr_ctl, n_wr_rst;
    int seq_rstlo, seq_rsthi;
    longint cyc, t_rstlo, t_rsthi, t_lock_prev, t_lock_last;

    always_ff @(posedge clk) begin
        cyc <= cyc + 1;
        if (log_clr) begin
            r_src <= pre_src; r_rst <= pre_rst; r_ref <= pre_ref; r_ctl <= pre_ctl; r_fac <= pre_fac;
            w_ref <= '0; w_src <= '0; w_ctl <= '0; w_rstlo <= '0; w_rsthi <= '0;
            txn <= 0; wcnt <= 0; lock_reads <= 0; fac_reads <= 0;
            n_wr_ref <= 0; n_wr_src <= 0; n_wr_ctl <= 0; n_wr_rst <= 0;
            seq_rstlo <= 0; seq_rsthi <= 0;
            t_rstlo <= 0; t_rsthi <= 0; t_lock_prev <= 0; t_lock_last <= 0;
            ready_r <= 1'b0; rdata_r <= '0;
        end else if (bus_req && !ready_r) begin
            if (wcnt >= (txn % 3)) begin
                ready_r <= 1'b1;
                wcnt <= 0;
                txn <= txn + 1;
                rdata_r <= '0;
                if (bus_we) begin
                    case (bus_addr)
                        12'h784: begin r_ref <= bus_wdata; w_ref <= bus_wdata; n_wr_ref <= n_wr_ref + 1; end
                        12'h028: begin r_src <= bus_wdata; w_src <= bus_wdata; n_wr_src <= n_wr_src + 1; end
                        12'h78C: begin r_ctl <= bus_wdata; w_ctl <= bus_wdata; n_wr_ctl <= n_wr_ctl + 1; end
                        12'h780: begin
                            r_rst <= bus_wdata;
                            n_wr_rst <= n_wr_rst + 1;
                            if (!bus_wdata[6]) begin w_rstlo <= bus_wdata; t_rstlo <= cyc; seq_rstlo <= txn; end
                            else begin w_rsthi <= bus_wdata; t_rsthi <= cyc; seq_rsthi <= txn; end
                        end
                        default: ;
                    endcase
                end else begin
                    case (bus_addr)
                        12'h028: rdata_r <= r_src;
                        12'h780: rdata_r <= r_rst;
                        12'h784: rdata_r <= r_ref;
                        12'h78C: rdata_r <= r_ctl;
                        12'h794: begin rdata_r <= r_fac; fac_reads <= fac_reads + 1; end
                        12'h064: begin
                            rdata_r <= (lock_reads >= lock_after) ? 32'h0000_0100 : 32'h0000_00FF;
                            lock_reads <= lock_reads + 1;
                            t_lock_prev <= t_lock_last;
                            t_lock_last <= cyc;
                        end
                        default: rdata_r <= '0;
                    endcase
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            ready_r <= 1'b0;
            wcnt <= 0;
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_log(input int lk);
        lock_after = lk;
        @(negedge clk) log_clr = 1'b1;
        @(negedge clk) log_clr = 1'b0;
    endtask

    task automatic pulse_start(input logic [16:0] khz);
        @(negedge clk);
        start = 1'b1;
        ref_khz = khz;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_ref(input logic [3:0] idx, input bit p96);
        logic [31:0] v;
        v = pre_ref;
        v[3:0] = idx;
        if (p96) v[8:4] = 5'd2;
        return v;
    endfunction

    task automatic t_reset_state();
        chk(!busy && !done && !error, "R11 reset flags", {busy, done, error}, 0);
        chk(err_code == 2'b00, "R11 reset code", err_code, 0);
        chk(!bus_req, "R9 reset bus idle", bus_req, 0);
    endtask

    task automatic t_full_run(input logic [16:0] khz, input logic [3:0] idx, input bit p96);
        clear_log(2);
        pulse_start(khz);
        chk(busy, "R11 busy after start", busy, 1);
        wait_idle();
        @(negedge clk);
        chk(w_ref == exp_ref(idx, p96), "R2 refcfg write", w_ref, exp_ref(idx, p96));
        chk(n_wr_ref == 1, "R2 refcfg write count", n_wr_ref, 1);
        if (p96) chk(n_wr_src == 1 && w_src == (pre_src & ~32'h300), "R3 srcsel write", w_src, pre_src & ~32'h300);
        else     chk(n_wr_src == 0, "R3 srcsel untouched", n_wr_src, 0);
        chk(w_ctl == (pre_ctl | 32'h8000), "R4 lock-detect enable", w_ctl, pre_ctl | 32'h8000);
        chk(w_rstlo == (pre_rst & ~32'h40), "R5 reset assert value", w_rstlo, pre_rst & ~32'h40);
        chk(w_rsthi == (pre_rst | 32'h40), "R5 reset release value", w_rsthi, pre_rst | 32'h40);
        chk(seq_rsthi == seq_rstlo + 1, "R5 no traffic in hold", seq_rsthi, seq_rstlo + 1);
        chk((t_rsthi - t_rstlo) >= HOLD && (t_rsthi - t_rstlo) <= HOLD + 10, "R5 hold length", t_rsthi - t_rstlo, HOLD);
        chk(lock_reads == 3 && fac_reads == 1, "R6 poll then factor", lock_reads, 3);
        chk((t_lock_last - t_lock_prev) >= POLL && (t_lock_last - t_lock_prev) <= POLL + 10, "R6 poll spacing", t_lock_last - t_lock_prev, POLL);
        chk(done && !error && err_code == 2'b00, "R6 done flag", {done, error}, 2'b10);
        chk(pll_rate_khz == 32'(khz) * 2 * 32'h3C, "R8 rate report", pll_rate_khz, 32'(khz) * 2 * 32'h3C);
    endtask

    task automatic t_table_sweep();
        t_full_run(17'd31250, 4'd4, 1'b0);
        t_full_run(17'd40000, 4'd6, 1'b0);
        t_full_run(17'd48000, 4'd7, 1'b0);
        t_full_run(17'd50000, 4'd8, 1'b0);
        chk(w_ref[3:0] == 4'd8, "R1 index for 50000", w_ref[3:0], 8);
    endtask

    task automatic t_unsupported();
        clear_log(0);
        pulse_start(17'd12345);
        chk(!busy && error && err_code == 2'b01 && !done, "R1 unsupported code", {busy, error, err_code}, 3'b101);
        repeat (20) @(negedge clk);
        chk(txn == 0 && !bus_req, "R1 no bus traffic", txn, 0);
    endtask

    task automatic t_timeout();
        clear_log(100000);
        pulse_start(17'd25000);
        wait_idle();
        @(negedge clk);
        chk(error && err_code == 2'b10 && !done, "R7 timeout code", err_code, 2'b10);
        chk(lock_reads == NPOLL, "R7 poll budget", lock_reads, NPOLL);
        chk(fac_reads == 0, "R7 factor not read", fac_reads, 0);
    endtask

    task automatic t_start_while_busy();
        clear_log(0);
        pulse_start(17'd25000);
        repeat (5) @(negedge clk);
        pulse_start(17'd50000);
        wait_idle();
        @(negedge clk);
        chk(n_wr_ref == 1 && w_ref[3:0] == 4'd3, "R10 second start ignored", w_ref[3:0], 3);
        chk(pll_rate_khz == 32'd25000 * 2 * 32'h3C, "R10 rate from first start", pll_rate_khz, 25000 * 2 * 60);
    endtask

    task automatic t_sticky();
        clear_log(0);
        pulse_start(17'd25000);
        wait_idle();
        repeat (30) @(negedge clk);
        chk(done && !busy, "R11 done sticky", done, 1);
        pulse_start(17'd12345);
        chk(!done && error, "R11 start clears done", done, 0);
        repeat (10) @(negedge clk);
        chk(error && err_code == 2'b01, "R11 error sticky", err_code, 1);
        pulse_start(17'd40000);
        chk(!error && busy, "R11 start clears error", error, 0);
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc = 0;
        log_clr = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        log_clr = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_full_run(17'd25000, 4'd3, 1'b0);
        t_full_run(17'd96000, 4'd7, 1'b1);
        t_table_sweep();
        t_unsupported();
        t_timeout();
        t_start_while_busy();
        t_sticky();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule